// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Shared Lock/Monitor Pin

This block sits behind the reference and feedback dividers of two synthesizer loops. Each channel receives two single-cycle pulses: one from the divided reference (ref) and one from the divided oscillator feedback (vco). A three-state detector turns the arrival order into charge-pump commands, source or sink. When neither command is active the pump is high-impedance. The detector covers a full ±2π error range. When both pulses have arrived, both commands stay on together for a short fixed time, so that near-zero phase error still produces pump activity and no dead zone appears. Each channel has four controls: a polarity select, a current-boost flag passed to the analog pump, a forced-off override, and a sleep input that parks the channel.

Each channel also has a lock detector. It measures how long only one command is active in each comparison and counts good comparisons in a row. A single shared pin carries one of several signals, chosen by a four-bit code: a lock indication, a raw divider pulse for monitoring, a fast-lock filter switch, or divider-reset requests. The pin is described by a drive enable and a level, so it can model an open-drain output.

Top module: `pfd_lockmux`

## Requirements
- R1: With pol_pos[c]=1, a ref pulse arriving first sets the up command, and pump_src[c]=1, pump_snk[c]=0 one cycle after the ref pulse. A vco pulse arriving first sets the down command, giving pump_src[c]=0, pump_snk[c]=1. The command holds until the other pulse arrives. With no command pending, both outputs are 0 (high-impedance).
- R2: With pol_pos[c]=0, the mapping is swapped: the up command drives pump_snk[c] and the down command drives pump_src[c].
- R3: Once both pulses of a comparison have been captured, pump_src[c] and pump_snk[c] are both 1 for exactly DZ_CYCLES (default 2) cycles. Then both clear together. Pulses arriving in the same cycle give the same 2-cycle overlap.
- R4: While force_off[c] or sleep[c] is 1, pump_src[c], pump_snk[c] and pump_boost[c] are all 0.
- R5: While the channel is neither forced off nor asleep, pump_boost[c] equals boost[c].
- R6: The phase error of a comparison is the number of cycles in which only one command is active. locked[c] rises at the end of the LOCK_NEED-th (default 8) consecutive comparison whose error is at most LOCK_WIN (default 2). An error equal to LOCK_WIN still counts as good.
- R7: A comparison with error above LOCK_WIN clears locked[c] at its end and restarts the count of good comparisons.
- R8: sleep[c]=1 clears that channel's pending commands and lock state within one cycle. Pulses arriving while asleep are ignored.
- R9: The pin code is {sel_lock[1], sel_lock[0], sel_mon[1], sel_mon[0]}, where bit 1 of each field refers to channel 1 and bit 0 to channel 0. All pin outputs are registered, one cycle after their inputs. With sel_mon=00:
  - sel_lock=00 gives mon_oe=0.
  - Otherwise mon_oe=1, and mon_val is the AND of the lock flags of the channels whose sel_lock bit is set.
- R10: With sel_mon=01 (channel 0) or 10 (channel 1), mon_oe=1 and mon_val shows that channel's ref pulse when sel_lock[0]=0, or its vco pulse when sel_lock[0]=1. sel_lock[1] has no effect in this mode.
- R11: With sel_mon=11 and sel_lock=00 (fast lock), the pin drives low (mon_oe=1, mon_val=0) while boost[1]=1, and is released (mon_oe=0) while boost[1]=0. boost[0] has no effect on the pin.
- R12: With sel_mon=11 and sel_lock nonzero, cnt_rst equals sel_lock (bit 1 resets channel 1's dividers, bit 0 channel 0's) and mon_oe=0. In every other code, cnt_rst=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 2 | Divided-reference pulse per channel, one cycle wide |
| vco_pulse | input | 2 | Divided-feedback pulse per channel, one cycle wide |
| pol_pos | input | 2 | Detector polarity per channel (1: ref-leading sources) |
| boost | input | 2 | Charge-pump current boost request per channel |
| force_off | input | 2 | Force pump high-impedance per channel |
| sleep | input | 2 | Power-save per channel |
| sel_lock | input | 2 | Pin code, lock/sub-select field |
| sel_mon | input | 2 | Pin code, monitor/special field |
| pump_src | output | 2 | Pump source command per channel |
| pump_snk | output | 2 | Pump sink command per channel |
| pump_boost | output | 2 | Boost flag to the pump per channel |
| locked | output | 2 | Lock flag per channel |
| mon_oe | output | 1 | Shared pin drive enable |
| mon_val | output | 1 | Shared pin level when driven |
| cnt_rst | output | 2 | Divider reset request per channel |

## Verification
The checks assume that the two pulses of a channel are single-cycle events spaced far enough apart that no new pulse reaches a channel while it is clearing after a comparison. They also assume that a ref or vco pulse never repeats before its partner has arrived. The bench keeps to this by running every comparison to completion, then idling for a few cycles before the next. It drives the leading pulse, waits a chosen gap, drives the trailing pulse, and only then starts the next comparison. Changes to the mode, polarity and override inputs are made only between comparisons, and outputs are sampled on the falling edge.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int CH_N = 2;

  typedef enum logic [1:0] {
    PIN_IDLE    = 2'd0,
    PIN_LOCK    = 2'd1,
    PIN_MON     = 2'd2,
    PIN_SPECIAL = 2'd3
  } pin_kind_e;

  function automatic pin_kind_e pin_kind(input logic [1:0] lk, input logic [1:0] mn);
    if (mn == 2'b11)       return PIN_SPECIAL;
    else if (mn != 2'b00)  return PIN_MON;
    else if (lk != 2'b00)  return PIN_LOCK;
    else                   return PIN_IDLE;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int DZ_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_p,
  input  logic vco_p,
  input  logic sleep,
  output logic up,
  output logic dn,
  output logic done
);

  localparam int CW = (DZ_CYCLES < 2) ? 1 : $clog2(DZ_CYCLES + 1);

  logic          up_q, up_n;
  logic          dn_q, dn_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          both;

  assign both = up_q & dn_q;
  assign done = both && (cnt_q == CW'(DZ_CYCLES - 1));

  always_comb begin
    up_n  = up_q;
    dn_n  = dn_q;
    cnt_n = cnt_q;
    if (sleep) begin
      up_n  = 1'b0;
      dn_n  = 1'b0;
      cnt_n = '0;
    end else if (both) begin
      if (done) begin
        up_n  = 1'b0;
        dn_n  = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else begin
      up_n = up_q | ref_p;
      dn_n = dn_q | vco_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_n;
      dn_q  <= dn_n;
      cnt_q <= cnt_n;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int LOCK_WIN  = 2,
  parameter int LOCK_NEED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic done,
  input  logic sleep,
  output logic locked
);

  localparam int EW = $clog2(LOCK_WIN + 2);
  localparam int GW = $clog2(LOCK_NEED + 1);

  logic [EW-1:0] err_q, err_n;
  logic [GW-1:0] good_q, good_n;
  logic          lock_q, lock_n;
  logic          err_sat;
  logic          good_cmp;

  assign err_sat  = (err_q == EW'(LOCK_WIN + 1));
  assign good_cmp = (err_q <= EW'(LOCK_WIN));

  always_comb begin
    err_n  = err_q;
    good_n = good_q;
    lock_n = lock_q;
    if (sleep) begin
      err_n  = '0;
      good_n = '0;
      lock_n = 1'b0;
    end else if (done) begin
      err_n = '0;
      if (good_cmp) begin
        if (good_q != GW'(LOCK_NEED)) good_n = good_q + 1'b1;
        lock_n = (good_q >= GW'(LOCK_NEED - 1));
      end else begin
        good_n = '0;
        lock_n = 1'b0;
      end
    end else if ((up ^ dn) && !err_sat) begin
      err_n = err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      err_q  <= err_n;
      good_q <= good_n;
      lock_q <= lock_n;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/pfd_pin_mux.sv
module pfd_pin_mux
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lk_sel,
  input  logic [1:0] mn_sel,
  input  logic [1:0] ref_p,
  input  logic [1:0] vco_p,
  input  logic [1:0] lock_in,
  input  logic       fast_boost,
  output logic       pin_oe,
  output logic       pin_val,
  output logic [1:0] rst_req
);

  pin_kind_e  kind;
  logic       oe_n, val_n;
  logic [1:0] rst_n_d;
  logic       oe_q, val_q;
  logic [1:0] rst_q;
  logic       mon_ch;

  assign kind   = pin_kind(lk_sel, mn_sel);
  assign mon_ch = mn_sel[1];

  always_comb begin
    oe_n    = 1'b0;
    val_n   = 1'b0;
    rst_n_d = 2'b00;
    unique case (kind)
      PIN_LOCK: begin
        oe_n  = 1'b1;
        val_n = (lock_in[0] | ~lk_sel[0]) & (lock_in[1] | ~lk_sel[1]);
      end
      PIN_MON: begin
        oe_n  = 1'b1;
        val_n = lk_sel[0] ? vco_p[mon_ch] : ref_p[mon_ch];
      end
      PIN_SPECIAL: begin
        if (lk_sel == 2'b00) begin
          oe_n = fast_boost;
        end else begin
          rst_n_d = lk_sel;
        end
      end
      default: begin
        oe_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
      rst_q <= 2'b00;
    end else begin
      oe_q  <= oe_n;
      val_q <= val_n;
      rst_q <= rst_n_d;
    end
  end

  assign pin_oe  = oe_q;
  assign pin_val = val_q;
  assign rst_req = rst_q;

endmodule

// File: rtl/pfd_lockmux.sv
module pfd_lockmux
  import pfd_pkg::*;
#(
  parameter int DZ_CYCLES = 2,
  parameter int LOCK_WIN  = 2,
  parameter int LOCK_NEED = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pulse,
  input  logic [1:0] vco_pulse,
  input  logic [1:0] pol_pos,
  input  logic [1:0] boost,
  input  logic [1:0] force_off,
  input  logic [1:0] sleep,
  input  logic [1:0] sel_lock,
  input  logic [1:0] sel_mon,
  output logic [1:0] pump_src,
  output logic [1:0] pump_snk,
  output logic [1:0] pump_boost,
  output logic [1:0] locked,
  output logic       mon_oe,
  output logic       mon_val,
  output logic [1:0] cnt_rst
);

  logic            rst_s1_q, rst_s2_q;
  logic [CH_N-1:0] up_w, dn_w, done_w, off_w;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pfd_core #(.DZ_CYCLES(DZ_CYCLES)) core_i (
      .clk   (clk),
      .rst_n (rst_s2_q),
      .ref_p (ref_pulse[c]),
      .vco_p (vco_pulse[c]),
      .sleep (sleep[c]),
      .up    (up_w[c]),
      .dn    (dn_w[c]),
      .done  (done_w[c])
    );

    pfd_lock_det #(.LOCK_WIN(LOCK_WIN), .LOCK_NEED(LOCK_NEED)) lock_i (
      .clk    (clk),
      .rst_n  (rst_s2_q),
      .up     (up_w[c]),
      .dn     (dn_w[c]),
      .done   (done_w[c]),
      .sleep  (sleep[c]),
      .locked (locked[c])
    );

    assign off_w[c]      = force_off[c] | sleep[c];
    assign pump_src[c]   = ~off_w[c] & (pol_pos[c] ? up_w[c] : dn_w[c]);
    assign pump_snk[c]   = ~off_w[c] & (pol_pos[c] ? dn_w[c] : up_w[c]);
    assign pump_boost[c] = ~off_w[c] & boost[c];
  end

  pfd_pin_mux pin_i (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .lk_sel     (sel_lock),
    .mn_sel     (sel_mon),
    .ref_p      (ref_pulse),
    .vco_p      (vco_pulse),
    .lock_in    (locked),
    .fast_boost (boost[1]),
    .pin_oe     (mon_oe),
    .pin_val    (mon_val),
    .rst_req    (cnt_rst)
  );

endmodule

// File: rtl/pfd_lockmux_chk.sv
module pfd_lockmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] force_off,
  input logic [1:0] sleep,
  input logic [1:0] pump_src,
  input logic [1:0] pump_snk,
  input logic [1:0] pump_boost,
  input logic [1:0] locked,
  input logic       mon_oe,
  input logic [1:0] cnt_rst,
  input logic [1:0] up_w,
  input logic [1:0] dn_w,
  input logic [1:0] done_w
);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_off[c] || sleep[c]) |-> (!pump_src[c] && !pump_snk[c] && !pump_boost[c]));

    // R3
    overlap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_w[c] && dn_w[c] && !done_w[c] && !sleep[c]) |=> (up_w[c] && dn_w[c]));

    // R3
    overlap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_w[c] |=> (!up_w[c] && !dn_w[c]));

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked[c]) |-> $past(done_w[c]));

    // R8
    sleep_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep[c] |=> (!locked[c] && !up_w[c] && !dn_w[c]));
  end

  // R12
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst != 2'b00) |-> !mon_oe);

endmodule

bind pfd_lockmux pfd_lockmux_chk chk_i (.*);

// File: tb/pfd_lockmux_tb_top.sv
module pfd_lockmux_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk;
  logic       rst_n;
  logic [1:0] ref_p, vco_p, pol, boost, force_off, sleep, sel_lock, sel_mon;
  logic [1:0] pump_src, pump_snk, pump_boost, locked, cnt_rst;
  logic       mon_oe, mon_val;

  int n_chk  = 0;
  int n_fail = 0;

  pfd_lockmux dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_pulse  (ref_p),
    .vco_pulse  (vco_p),
    .pol_pos    (pol),
    .boost      (boost),
    .force_off  (force_off),
    .sleep      (sleep),
    .sel_lock   (sel_lock),
    .sel_mon    (sel_mon),
    .pump_src   (pump_src),
    .pump_snk   (pump_snk),
    .pump_boost (pump_boost),
    .locked     (locked),
    .mon_oe     (mon_oe),
    .mon_val    (mon_val),
    .cnt_rst    (cnt_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  // one comparison on channel c; k>0 ref leads by k cycles, k<0 vco leads
  task automatic compare_once(input int c, input int k, input bit do_chk, input string tag);
    int   m;
    bit   ref_first;
    logic p, on;
    m         = (k < 0) ? -k : k;
    ref_first = (k >= 0);
    p         = pol[c];
    on        = !(force_off[c] | sleep[c]);
    @(negedge clk);
    if (ref_first || m == 0) ref_p[c] = 1'b1;
    if (!ref_first || m == 0) vco_p[c] = 1'b1;
    @(negedge clk);
    ref_p[c] = 1'b0;
    vco_p[c] = 1'b0;
    if (m > 0) begin
      if (do_chk) begin
        check({tag, " single src"}, pump_src[c], on & (ref_first ? p : !p));
        check({tag, " single snk"}, pump_snk[c], on & (ref_first ? !p : p));
      end
      repeat (m - 1) @(negedge clk);
      if (ref_first) vco_p[c] = 1'b1;
      else           ref_p[c] = 1'b1;
      @(negedge clk);
      ref_p[c] = 1'b0;
      vco_p[c] = 1'b0;
    end
    if (do_chk) check({tag, " overlap1"}, {pump_src[c], pump_snk[c]}, {on, on});
    @(negedge clk);
    if (do_chk) check({tag, " overlap2"}, {pump_src[c], pump_snk[c]}, {on, on});
    @(negedge clk);
    if (do_chk) check({tag, " released"}, {pump_src[c], pump_snk[c]}, 2'b00);
  endtask

  task automatic set_mode(input logic [1:0] lk, input logic [1:0] mn);
    @(negedge clk);
    sel_lock = lk;
    sel_mon  = mn;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset src", pump_src, 2'b00);
    check("R1 reset snk", pump_snk, 2'b00);
    check("R6 reset lock", locked, 2'b00);
    check("R9 reset pin oe", {1'b0, mon_oe}, 2'b00);
    check("R12 reset cnt_rst", cnt_rst, 2'b00);
  endtask

  task automatic t_pol_pos();
    pol[0] = 1'b1;
    compare_once(0, 3, 1'b1, "R1 ref-lead");
    compare_once(0, -2, 1'b1, "R1 vco-lead");
    compare_once(0, 0, 1'b1, "R3 same-cycle");
    compare_once(0, 1, 1'b1, "R3 gap1");
  endtask

  task automatic t_pol_neg();
    pol[1] = 1'b0;
    compare_once(1, 2, 1'b1, "R2 ref-lead");
    compare_once(1, -3, 1'b1, "R2 vco-lead");
  endtask

  task automatic t_lock();
    compare_once(0, 4, 1'b0, "R7 clear count");
    check("R7 bad comparison unlocks", locked[0], 1'b0);
    for (int i = 0; i < 7; i++) compare_once(0, 1, 1'b0, "R6");
    check("R6 seven good not locked", locked[0], 1'b0);
    compare_once(0, 1, 1'b0, "R6");
    check("R6 eighth good locks", locked[0], 1'b1);
    compare_once(0, -2, 1'b0, "R6");
    check("R6 error at window keeps lock", locked[0], 1'b1);
    compare_once(0, 3, 1'b0, "R7");
    check("R7 error above window drops lock", locked[0], 1'b0);
    for (int i = 0; i < 7; i++) compare_once(0, 2, 1'b0, "R6");
    check("R7 count restarted", locked[0], 1'b0);
    compare_once(0, -2, 1'b0, "R6");
    check("R6 window-edge comparisons lock", locked[0], 1'b1);
  endtask

  task automatic t_pin_lock();
    check("R7 ch1 unlocked after bad", locked[1], 1'b0);
    set_mode(2'b01, 2'b00);
    check("R9 ch0 lock shown", {mon_oe, mon_val}, 2'b11);
    set_mode(2'b10, 2'b00);
    check("R9 ch1 lock shown", {mon_oe, mon_val}, 2'b10);
    set_mode(2'b11, 2'b00);
    check("R9 both lock one missing", {mon_oe, mon_val}, 2'b10);
    set_mode(2'b00, 2'b00);
    check("R9 disabled", {mon_oe, cnt_rst[0]}, 2'b00);
    for (int i = 0; i < 8; i++) compare_once(1, 0, 1'b0, "R6");
    set_mode(2'b11, 2'b00);
    check("R9 both locked", {mon_oe, mon_val}, 2'b11);
  endtask

  task automatic mon_case(input int c, input logic [1:0] lk, input string tag);
    set_mode(lk, (c == 0) ? 2'b01 : 2'b10);
    @(negedge clk);
    ref_p[c] = 1'b1;
    @(negedge clk);
    ref_p[c] = 1'b0;
    check({tag, " ref cycle"}, {mon_oe, mon_val}, {1'b1, !lk[0]});
    vco_p[c] = 1'b1;
    @(negedge clk);
    vco_p[c] = 1'b0;
    check({tag, " vco cycle"}, {mon_oe, mon_val}, {1'b1, lk[0]});
    @(negedge clk);
    check({tag, " idle"}, {mon_oe, mon_val}, 2'b10);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pin_mon();
    mon_case(0, 2'b00, "R10 ch0 ref");
    mon_case(0, 2'b01, "R10 ch0 vco");
    mon_case(1, 2'b10, "R10 ch1 ref, upper select ignored");
    mon_case(1, 2'b11, "R10 ch1 vco, upper select ignored");
    check("R10 locks kept", locked, 2'b11);
  endtask

  task automatic t_fast();
    boost = 2'b10;
    set_mode(2'b00, 2'b11);
    check("R11 fast lock drives low", {mon_oe, mon_val}, 2'b10);
    check("R11 no reset", cnt_rst, 2'b00);
    boost = 2'b01;
    @(negedge clk);
    check("R11 released, ch0 boost ignored", {mon_oe, mon_val}, 2'b00);
    boost = 2'b00;
  endtask

  task automatic t_rst();
    set_mode(2'b01, 2'b11);
    check("R12 reset ch0", {mon_oe, cnt_rst}, 3'b001);
    set_mode(2'b10, 2'b11);
    check("R12 reset ch1", {mon_oe, cnt_rst}, 3'b010);
    set_mode(2'b11, 2'b11);
    check("R12 reset both", {mon_oe, cnt_rst}, 3'b011);
    set_mode(2'b00, 2'b00);
    check("R12 reset cleared", cnt_rst, 2'b00);
  endtask

  task automatic t_off();
    @(negedge clk);
    force_off[0] = 1'b1;
    boost[0]     = 1'b1;
    compare_once(0, 2, 1'b1, "R4 forced off");
    check("R4 boost gated", pump_boost[0], 1'b0);
    force_off[0] = 1'b0;
    #0.1;
    check("R5 boost follows", pump_boost, 2'b01);
    boost[0] = 1'b0;
    #0.1;
    check("R5 boost follows low", pump_boost, 2'b00);
  endtask

  task automatic t_sleep();
    check("R8 locked before sleep", locked[0], 1'b1);
    @(negedge clk);
    sleep[0] = 1'b1;
    ref_p[0] = 1'b1;
    @(negedge clk);
    ref_p[0] = 1'b0;
    check("R8 sleep unlocks", locked[0], 1'b0);
    check("R4 sleep quiets pump", {pump_src[0], pump_snk[0]}, 2'b00);
    @(negedge clk);
    sleep[0] = 1'b0;
    @(negedge clk);
    check("R8 pulse during sleep ignored", {pump_src[0], pump_snk[0]}, 2'b00);
    compare_once(0, 1, 1'b1, "R8 after wake");
    check("R8 lock count restarted", locked[0], 1'b0);
  endtask

  initial begin
    rst_n     = 1'b0;
    ref_p     = '0;
    vco_p     = '0;
    pol       = 2'b11;
    boost     = '0;
    force_off = '0;
    sleep     = '0;
    sel_lock  = '0;
    sel_mon   = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pol_pos();
    t_pol_neg();
    t_lock();
    t_pin_lock();
    t_pin_mon();
    t_fast();
    t_rst();
    t_off();
    t_sleep();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule